// File: doc/BRIEF.md
# Serial PSRAM Command Frame Builder

This block sits between a simple memory requester and a byte-wide serial shifter that drives a quad-pin-free, single-bit SPI pseudo-static RAM. It takes one request at a time, either a read or a write of 1, 2 or 4 bytes at a 24-bit address, and turns it into a stream of bytes for the shifter. Every stream opens with two count bytes that tell the shifter how many bits to clock out and how many to clock back in. The command opcode, the address and then either the write data or one dummy byte for the fast-read wait follow the counts.

For a read, the shifter later returns the requested bytes one per `rx_valid` strobe. The block packs them into a response word and raises a one-cycle `rsp_done`. Requests come in on a valid/ready handshake. `req_ready` is high only while the controller is idle, so a new access cannot begin until the previous frame is fully sent and any read data has come back. A request with an unsupported size is taken and dropped with a one-cycle `req_err`, and no bytes go out.

The controller has three named states. `FG_IDLE` waits for a request. A legal request takes the *accept* transition to `FG_SEND`, and an illegal one takes the *reject* self-loop. `FG_SEND` presents frame bytes on `tx_byte`. When a write frame's last byte is accepted, the *write-complete* transition returns to `FG_IDLE`. When a read frame's last byte is accepted, the *read-issued* transition moves to `FG_RECV`. `FG_RECV` collects bytes, and its *read-complete* transition back to `FG_IDLE` fires on the last one.

Top module: `psram_frame_gen`

## Requirements
- R1: Frame byte 0 is the transmit bit count: (4+N)*8 for an N-byte write (40, 48, 64) and 40 for every read. Frame byte 1 is the receive bit count: N*8 for a read (8, 16, 32) and 0 for a write.
- R2: Frame byte 2 is the opcode: 0x02 for a write and 0x0B (fast read) for a read.
- R3: Frame bytes 3, 4 and 5 carry the 24-bit address, most significant byte first.
- R4: A read frame has exactly 7 bytes, and byte 6 is a 0x00 dummy byte.
- R5: A write frame has exactly 6+N bytes. Bytes 6 onward carry the write data, least significant byte first.
- R6: A presented frame byte advances only on a cycle with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, `tx_valid` and `tx_byte` hold.
- R7: `req_ready` is high only when the controller is idle. `busy` rises the cycle after a legal request is accepted. For a write, `busy` falls the cycle after the last frame byte is accepted. For a read, it falls the cycle after the last response byte is received.
- R8: Read data is assembled with the first received byte as the least significant byte, and unused upper bytes read as zero. `rsp_done` pulses for one cycle, in the cycle after the last byte arrives, with `rsp_data` updated in that same cycle. `rsp_data` then holds until the next read completes.
- R9: A request with size code 0, 3, 5, 6 or 7 is accepted and dropped. `req_err` pulses for one cycle in the following cycle, and `busy` and `tx_valid` stay low.
- R10: `rx_valid` strobes outside the receive phase, whether idle or while the frame is still being sent, are ignored and do not alter the response.
- R11: After reset the controller is idle: `req_ready` high, and `busy`, `tx_valid`, `rsp_done` and `req_err` low, with `rsp_data` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_wdata | input | 32 | Write data, byte 0 sent first |
| req_err | output | 1 | One-cycle pulse on an illegal size |
| tx_valid | output | 1 | Frame byte present for the shifter |
| tx_ready | input | 1 | Shifter takes the frame byte |
| tx_byte | output | 8 | Frame byte |
| rx_valid | input | 1 | Returned read byte present |
| rx_byte | input | 8 | Returned read byte |
| rsp_done | output | 1 | One-cycle pulse when read data is complete |
| rsp_data | output | 32 | Assembled read word |
| busy | output | 1 | An access is in progress |

## Verification
The checks assume three things about the surroundings. The shifter returns exactly N response bytes, at most one per cycle. It starts returning them only after the read frame has been fully accepted. Every request field is valid in the cycle `req_valid` is high. The stimulus drives one request at a time while `req_ready` is high and returns read bytes only after the last frame byte has been taken. The only exception is deliberate stray `rx_valid` strobes, sent while idle and mid-frame to exercise R10. Back-pressure comes from a set of `tx_ready` stall patterns, so the hold behaviour is exercised without the shifter ever dropping a presented byte.

// File: rtl/psram_frame_pkg.sv
package psram_frame_pkg;

    localparam logic [7:0] OP_WRITE      = 8'h02;
    localparam logic [7:0] OP_FAST_READ  = 8'h0B;

    // Address bytes follow the opcode, most significant first.
    localparam int ADDR_BYTES     = 3;
    // Two count bytes followed by the opcode.
    localparam int PREFIX_BYTES   = 3;
    // Opcode plus address: the part of the transmit count common to all frames.
    localparam int CMD_ADDR_BYTES = 1 + ADDR_BYTES;
    // One dummy byte gives the fast-read wait of eight serial clocks.
    localparam int DUMMY_BYTES    = 1;
    localparam int DATA_START     = PREFIX_BYTES + ADDR_BYTES;
    localparam int READ_FRAME_LEN = DATA_START + DUMMY_BYTES;

    typedef enum logic [1:0] {
        FG_IDLE = 2'd0,
        FG_SEND = 2'd1,
        FG_RECV = 2'd2
    } fg_state_e;

endpackage

// File: rtl/psram_size_check.sv
module psram_size_check #(
    parameter int DATA_BYTES = 4,
    parameter int SIZE_W     = 3
) (
    input  logic [SIZE_W-1:0] size_code,
    output logic              legal
);
    logic [SIZE_W-1:0] hit;

    // One lane per power of two that fits in the data word.
    for (genvar i = 0; i < SIZE_W; i++) begin : g_lane
        localparam int LANE = 1 << i;
        if (LANE <= DATA_BYTES) begin : g_fit
            assign hit[i] = (size_code == SIZE_W'(LANE));
        end else begin : g_none
            assign hit[i] = 1'b0;
        end
    end

    assign legal = |hit;

endmodule

// File: rtl/psram_frame_mux.sv
module psram_frame_mux
    import psram_frame_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    parameter int SIZE_W     = 3,
    parameter int IDX_W      = 4
) (
    input  logic                    is_write,
    input  logic [8*ADDR_BYTES-1:0] addr,
    input  logic [SIZE_W-1:0]       nbytes,
    input  logic [8*DATA_BYTES-1:0] wdata,
    input  logic [IDX_W-1:0]        idx,
    output logic [7:0]              frame_byte,
    output logic [IDX_W-1:0]        last_idx
);
    logic [7:0] tx_bits;
    logic [7:0] rx_bits;
    logic [7:0] data_lane [DATA_BYTES];
    logic [7:0] addr_lane [ADDR_BYTES];

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_data
        assign data_lane[g] = wdata[8*g +: 8];
    end

    // Address lane 0 is the first address byte on the wire (the most significant).
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
        assign addr_lane[g] = addr[8*(ADDR_BYTES-1-g) +: 8];
    end

    assign tx_bits = is_write ? 8'((int'(nbytes) + CMD_ADDR_BYTES) * 8)
                              : 8'((CMD_ADDR_BYTES + DUMMY_BYTES) * 8);
    assign rx_bits = is_write ? 8'h00 : 8'(int'(nbytes) * 8);

    assign last_idx = is_write ? IDX_W'(DATA_START - 1) + IDX_W'(nbytes)
                               : IDX_W'(READ_FRAME_LEN - 1);

    always_comb begin
        frame_byte = 8'h00;
        if (idx == IDX_W'(0)) begin
            frame_byte = tx_bits;
        end else if (idx == IDX_W'(1)) begin
            frame_byte = rx_bits;
        end else if (idx == IDX_W'(2)) begin
            frame_byte = is_write ? OP_WRITE : OP_FAST_READ;
        end else begin
            for (int k = 0; k < ADDR_BYTES; k++) begin
                if (idx == IDX_W'(PREFIX_BYTES + k)) frame_byte = addr_lane[k];
            end
            if (is_write) begin
                for (int k = 0; k < DATA_BYTES; k++) begin
                    if (idx == IDX_W'(DATA_START + k)) frame_byte = data_lane[k];
                end
            end
        end
    end

endmodule

// File: rtl/psram_rd_assemble.sv
module psram_rd_assemble #(
    parameter int DATA_BYTES = 4,
    parameter int SIZE_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    take,
    input  logic [7:0]              rx_byte,
    input  logic [SIZE_W-1:0]       nbytes,
    output logic [8*DATA_BYTES-1:0] word,
    output logic                    last
);
    logic [SIZE_W-1:0] cnt_q;
    logic [7:0]        lane_q [DATA_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int k = 0; k < DATA_BYTES; k++) lane_q[k] <= 8'h00;
        end else if (clear) begin
            cnt_q <= '0;
            for (int k = 0; k < DATA_BYTES; k++) lane_q[k] <= 8'h00;
        end else if (take) begin
            for (int k = 0; k < DATA_BYTES; k++) begin
                if (cnt_q == SIZE_W'(k)) lane_q[k] <= rx_byte;
            end
            cnt_q <= cnt_q + SIZE_W'(1);
        end
    end

    // The arriving byte is merged in, so the word is complete on the last strobe.
    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_word
        assign word[8*g +: 8] = (take && (cnt_q == SIZE_W'(g))) ? rx_byte : lane_q[g];
    end

    assign last = (cnt_q == nbytes - SIZE_W'(1));

endmodule

// File: rtl/psram_frame_gen.sv
module psram_frame_gen
    import psram_frame_pkg::*;
#(
    parameter int  DATA_BYTES = 4,
    localparam int SIZE_W     = $clog2(DATA_BYTES) + 1,
    localparam int DATA_W     = 8 * DATA_BYTES,
    localparam int ADDR_W     = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_err,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_byte,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic              busy
);
    localparam int FRAME_MAX = DATA_START + DATA_BYTES;
    localparam int IDX_W     = $clog2(FRAME_MAX + 1);

    fg_state_e         state_q, state_d;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_q;
    logic [DATA_W-1:0] wdata_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx;
    logic              err_q;
    logic              done_q;
    logic [DATA_W-1:0] rsp_q;

    logic              size_ok;
    logic              accept;
    logic              start;
    logic              reject;
    logic              tx_fire;
    logic              tx_last;
    logic              rx_take;
    logic              rd_last;
    logic [DATA_W-1:0] rd_word;

    psram_size_check #(
        .DATA_BYTES (DATA_BYTES),
        .SIZE_W     (SIZE_W)
    ) u_size (
        .size_code (req_size),
        .legal     (size_ok)
    );

    psram_frame_mux #(
        .DATA_BYTES (DATA_BYTES),
        .SIZE_W     (SIZE_W),
        .IDX_W      (IDX_W)
    ) u_mux (
        .is_write   (wr_q),
        .addr       (addr_q),
        .nbytes     (size_q),
        .wdata      (wdata_q),
        .idx        (idx_q),
        .frame_byte (tx_byte),
        .last_idx   (last_idx)
    );

    psram_rd_assemble #(
        .DATA_BYTES (DATA_BYTES),
        .SIZE_W     (SIZE_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .take    (rx_take),
        .rx_byte (rx_byte),
        .nbytes  (size_q),
        .word    (rd_word),
        .last    (rd_last)
    );

    assign accept  = req_valid && req_ready;
    assign start   = accept && size_ok;
    assign reject  = accept && !size_ok;
    assign tx_fire = tx_valid && tx_ready;
    assign tx_last = (idx_q == last_idx);
    assign rx_take = (state_q == FG_RECV) && rx_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FG_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept / reject, write-complete, read-issued, read-complete
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FG_IDLE: if (start) state_d = FG_SEND;
            FG_SEND: if (tx_fire && tx_last) state_d = wr_q ? FG_IDLE : FG_RECV;
            FG_RECV: if (rx_take && rd_last) state_d = FG_IDLE;
            default: state_d = FG_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        req_ready = 1'b0;
        tx_valid  = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            FG_IDLE: begin
                req_ready = 1'b1;
                busy      = 1'b0;
            end
            FG_SEND: tx_valid = 1'b1;
            FG_RECV: ;
            default: busy = 1'b0;
        endcase
    end

    // Request capture and frame index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            size_q  <= '0;
            wdata_q <= '0;
            idx_q   <= '0;
        end else if (start) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            size_q  <= req_size;
            wdata_q <= req_wdata;
            idx_q   <= '0;
        end else if (tx_fire) begin
            idx_q   <= idx_q + IDX_W'(1);
        end
    end

    // Pulses and response word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            done_q <= 1'b0;
            rsp_q  <= '0;
        end else begin
            err_q  <= reject;
            done_q <= rx_take && rd_last;
            if (rx_take && rd_last) rsp_q <= rd_word;
        end
    end

    assign req_err  = err_q;
    assign rsp_done = done_q;
    assign rsp_data = rsp_q;

endmodule

// File: rtl/psram_frame_gen_chk.sv
module psram_frame_gen_chk #(
    parameter int  DATA_BYTES = 4,
    localparam int SIZE_W     = $clog2(DATA_BYTES) + 1,
    localparam int DATA_W     = 8 * DATA_BYTES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [SIZE_W-1:0] req_size,
    input logic              req_err,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_byte,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_data,
    input logic              busy
);
    logic size_legal;
    assign size_legal = (req_size != '0) && ((req_size & (req_size - SIZE_W'(1))) == '0)
                        && (int'(req_size) <= DATA_BYTES);

    a_r7_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && size_legal) |=> busy);

    a_r9_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !size_legal) |=> (req_err && !busy && !tx_valid));

    a_r6_hold_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> $stable(rsp_data));

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!busy && $past(busy)));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tx_valid);

endmodule

bind psram_frame_gen psram_frame_gen_chk #(.DATA_BYTES(DATA_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_size  (req_size),
    .req_err   (req_err),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_byte   (tx_byte),
    .rsp_done  (rsp_done),
    .rsp_data  (rsp_data),
    .busy      (busy)
);

// File: tb/psram_frame_gen_tb_top.sv
module psram_frame_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_err;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rsp_done;
    logic [31:0] rsp_data;
    logic        busy;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] last_rsp = '0;

    always #10 clk = ~clk;

    psram_frame_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .req_err   (req_err),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_byte   (tx_byte),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rsp_done  (rsp_done),
        .rsp_data  (rsp_data),
        .busy      (busy)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_for(input bit wr, input int k);
        if (k < 2)  return "R1";
        if (k == 2) return "R2";
        if (k < 6)  return "R3";
        return wr ? "R5" : "R4";
    endfunction

    task automatic run_req(input bit wr, input logic [23:0] a, input int n,
                           input logic [31:0] wd, input logic [31:0] rd, input int stall);
        logic [7:0]  exp_f [16];
        logic [31:0] exp_rsp;
        int len;
        int k;
        int cyc;
        bit rdy;
        exp_f[0] = wr ? 8'((4 + n) * 8) : 8'd40;
        exp_f[1] = wr ? 8'd0 : 8'(n * 8);
        exp_f[2] = wr ? 8'h02 : 8'h0B;
        exp_f[3] = a[23:16];
        exp_f[4] = a[15:8];
        exp_f[5] = a[7:0];
        if (wr) begin
            for (int i = 0; i < n; i++) exp_f[6+i] = wd[8*i +: 8];
            len = 6 + n;
        end else begin
            exp_f[6] = 8'h00;
            len = 7;
        end

        @(negedge clk);
        check("R7", "ready when idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_size = 3'(n); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7", "busy after accept", {31'd0, busy}, 32'd1);
        check("R7", "ready low while busy", {31'd0, req_ready}, 32'd0);

        k = 0; cyc = 0;
        while (k < len && cyc < 400) begin
            rdy = (stall == 0) ? 1'b1 : ((cyc % (stall + 1)) == stall);
            tx_ready = rdy;
            // R10: stray return strobe while the frame is still being sent
            rx_valid = !wr && (k == 2);
            rx_byte  = 8'hDD;
            check("R6", "tx_valid during frame", {31'd0, tx_valid}, 32'd1);
            check(tag_for(wr, k), $sformatf("frame byte %0d", k), {24'd0, tx_byte}, {24'd0, exp_f[k]});
            @(negedge clk);
            if (rdy) k++;
            cyc++;
        end
        tx_ready = 1'b0;
        rx_valid = 1'b0;
        check("R6", "frame completed", k, len);

        if (wr) begin
            check("R7", "busy falls after write", {31'd0, busy}, 32'd0);
            check("R5", "no extra byte after write", {31'd0, tx_valid}, 32'd0);
            check("R8", "rsp held across write", rsp_data, last_rsp);
        end else begin
            check("R4", "no extra byte after read frame", {31'd0, tx_valid}, 32'd0);
            check("R7", "busy while receiving", {31'd0, busy}, 32'd1);
            exp_rsp = '0;
            for (int i = 0; i < n; i++) exp_rsp[8*i +: 8] = rd[8*i +: 8];
            for (int b = 0; b < n; b++) begin
                rx_valid = 1'b1;
                rx_byte  = rd[8*b +: 8];
                @(negedge clk);
                rx_valid = 1'b0;
                if (b == n - 1) begin
                    check("R8", "done pulse", {31'd0, rsp_done}, 32'd1);
                    check("R8", "read word", rsp_data, exp_rsp);
                    check("R7", "busy falls after read", {31'd0, busy}, 32'd0);
                end else begin
                    check("R8", "no early done", {31'd0, rsp_done}, 32'd0);
                    check("R7", "busy mid read", {31'd0, busy}, 32'd1);
                    @(negedge clk);
                end
            end
            @(negedge clk);
            check("R8", "done one cycle", {31'd0, rsp_done}, 32'd0);
            check("R8", "word held", rsp_data, exp_rsp);
            last_rsp = exp_rsp;
        end
    endtask

    task automatic bad_size(input int sz);
        @(negedge clk);
        req_valid = 1'b1; req_write = sz[0]; req_size = 3'(sz);
        req_addr = 24'h0F0F0F; req_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", $sformatf("err pulse size %0d", sz), {31'd0, req_err}, 32'd1);
        check("R9", "no busy on reject", {31'd0, busy}, 32'd0);
        check("R9", "no frame on reject", {31'd0, tx_valid}, 32'd0);
        @(negedge clk);
        check("R9", "err one cycle", {31'd0, req_err}, 32'd0);
        check("R9", "still no frame", {31'd0, tx_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] addrs [4];
        int sizes [3];
        int t;
        addrs[0] = 24'h000000; addrs[1] = 24'hFFFFFF;
        addrs[2] = 24'h123456; addrs[3] = 24'hA50F3C;
        sizes[0] = 1; sizes[1] = 2; sizes[2] = 4;

        repeat (3) @(negedge clk);
        check("R11", "ready in reset", {31'd0, req_ready}, 32'd1);
        check("R11", "busy in reset", {31'd0, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "ready after reset", {31'd0, req_ready}, 32'd1);
        check("R11", "busy after reset", {31'd0, busy}, 32'd0);
        check("R11", "tx idle", {31'd0, tx_valid}, 32'd0);
        check("R11", "no done", {31'd0, rsp_done}, 32'd0);
        check("R11", "no err", {31'd0, req_err}, 32'd0);
        check("R11", "rsp zero", rsp_data, 32'd0);

        // R10: strobes while idle change nothing
        rx_valid = 1'b1; rx_byte = 8'hEE;
        repeat (2) @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
        check("R10", "idle strobe no done", {31'd0, rsp_done}, 32'd0);
        check("R10", "idle strobe no data", rsp_data, 32'd0);
        check("R10", "idle strobe no busy", {31'd0, busy}, 32'd0);

        t = 0;
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 3; s++) begin
                for (int ai = 0; ai < 4; ai++) begin
                    run_req(w[0], addrs[ai], sizes[s],
                            32'h9E3779B9 * (t + 1), 32'hC2B2AE35 ^ (32'h01010101 * t),
                            t % 3);
                    t++;
                end
            end
        end
        // Interleave reads and writes so held data is checked across writes
        for (int i = 0; i < 6; i++) begin
            run_req(i[0], addrs[i % 4], sizes[i % 3], 32'h0BADF00D + i, 32'h87654321 + i, (i + 1) % 3);
        end

        foreach (sizes[i]) begin end
        bad_size(0); bad_size(3); bad_size(5); bad_size(6); bad_size(7);
        check("R8", "rsp held after rejects", rsp_data, last_rsp);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule